// File: doc/BRIEF.md
# Power-Down and Start-Up Sequencer

This block governs when the digital path of a stereo converter may produce data. An active-low power-down input parks the block in an off state. In that state the decimation filters are held in reset and both channel outputs read zero. When power-down is released, the block waits until the master clock and the frame clock are both seen toggling. It then runs a start-up period of a fixed number of frame-clock edges, with both channels still forced to two's complement zero. Only after that period does it pass sample data through and raise its ready flag.

All inputs are sampled by a fast system clock. The power-down input and both converter clocks pass through two-flop synchronizers. A clock counts as present while its synchronized level has changed within a parameterized number of system cycles. The format select chooses which frame-clock edge marks a frame start. A left-justified stream uses the rising edge and an I2S stream uses the falling edge. Start-up counting and the frame-start pulse both use that selected edge.

Top module: `pdn_init_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it, `filt_rst` = 1, `force_zero` = 1, `ready` = 0, and `out_l`/`out_r` read zero whatever `smp_l`/`smp_r` carry.
- R2: A low `pdn_n` puts the block in the off state from any other state within three system cycles. In that state `filt_rst` = 1, `force_zero` = 1 and `ready` = 0.
- R3: After `pdn_n` goes high, the block shows `filt_rst` = 0, `force_zero` = 1 and `ready` = 0 until both clocks are present. A clock is absent once its level has not changed for `MCLK_LIMIT` (master) or `FRAME_LIMIT` (frame) system cycles. The off state never leads straight to `ready`.
- R4: Start-up lasts exactly `INIT_FRAMES` selected frame-clock edges, 4129 by default. `ready` rises within three system cycles of the last of them and not before.
- R5: Whenever `ready` is 0, `out_l` and `out_r` are all-zero, whatever the sample inputs carry.
- R6: Once running, `out_l` = `smp_l` and `out_r` = `smp_r`. `ready` = 1 and `force_zero` = 0 hold together.
- R7: With `fmt_i2s` = 0 the selected frame edge is rising. With `fmt_i2s` = 1 it is falling. `frame_start` pulses for exactly one system cycle per selected edge, and never for the other edge, whenever the block is not in the off state.
- R8: If either clock becomes absent during start-up or running, the block returns to waiting, with `ready` = 0, zero outputs and `filt_rst` = 0. When the clocks return, start-up begins again from a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every converter clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_n | input | 1 | Power-down request, active low, asynchronous |
| mclk_in | input | 1 | Converter master clock, sampled as data |
| frame_clk | input | 1 | Frame (left/right) clock, sampled as data |
| fmt_i2s | input | 1 | 0: left-justified, rising edge starts a frame; 1: I2S, falling edge |
| smp_l | input | DATA_W | Left-channel sample from the filter |
| smp_r | input | DATA_W | Right-channel sample from the filter |
| filt_rst | output | 1 | Holds the filters in reset while powered down |
| force_zero | output | 1 | High while outputs are forced to zero |
| ready | output | 1 | High once start-up has completed and data is valid |
| frame_start | output | 1 | One-cycle pulse on each selected frame edge |
| out_l | output | DATA_W | Left-channel output, zero unless running |
| out_r | output | DATA_W | Right-channel output, zero unless running |

## Verification
The hardest condition to reach is the exact end of start-up, one edge short of the count and then on it. Reaching it needs thousands of frame edges, with the first counted edge known without doubt. The bench keeps both clocks running while power-down is asserted. It releases power-down one cycle after a selected edge, so the block is already counting before the next one. It then samples `ready` a few cycles after edge 4128 and again after edge 4129, once for each format. Loss of a clock is reached by stopping the frame-clock generator in the running state for longer than the absence limit.

// File: rtl/pis_pkg.sv
package pis_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_INIT = 2'd2,
        ST_RUN  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic filt_rst;
        logic force_zero;
        logic ready;
    } seq_ctl_t;

    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic seq_ctl_t ctl_of(input seq_state_e s);
        seq_ctl_t c;
        c.filt_rst   = (s == ST_OFF);
        c.force_zero = (s != ST_RUN);
        c.ready      = (s == ST_RUN);
        return c;
    endfunction

endpackage

// File: rtl/pis_sync.sv
module pis_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pis_clk_watch.sv
module pis_clk_watch #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic present
);
    localparam int W = pis_pkg::bits_for(LIMIT);

    logic         prev;
    logic [W-1:0] idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            idle <= W'(LIMIT);
        end else begin
            prev <= lvl;
            if (lvl != prev)
                idle <= '0;
            else if (idle != W'(LIMIT))
                idle <= idle + 1'b1;
        end
    end

    assign present = (idle != W'(LIMIT));
endmodule

// File: rtl/pis_fsm.sv
module pis_fsm
    import pis_pkg::*;
#(
    parameter int INIT_FRAMES = 4129
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pdn_ok,
    input  logic       mclk_ok,
    input  logic       fclk_ok,
    input  logic       frame_lvl,
    input  logic       fmt_i2s,
    output seq_state_e state,
    output logic       frame_start
);
    localparam int FR   = (INIT_FRAMES < 1) ? 1 : INIT_FRAMES;
    localparam int CW   = bits_for(FR);
    localparam int LAST = FR - 1;

    logic          frame_prev;
    logic          tick;
    logic          clocks_ok;
    logic [CW-1:0] cnt, cnt_nxt;
    seq_state_e    nxt;

    assign tick      = fmt_i2s ? (frame_prev & ~frame_lvl) : (~frame_prev & frame_lvl);
    assign clocks_ok = mclk_ok & fclk_ok;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        case (state)
            ST_OFF:  if (pdn_ok) nxt = ST_WAIT;
            ST_WAIT: if (clocks_ok) begin
                         nxt     = ST_INIT;
                         cnt_nxt = '0;
                     end
            ST_INIT: if (!clocks_ok) begin
                         nxt = ST_WAIT;
                     end else if (tick) begin
                         if (cnt == CW'(LAST)) nxt = ST_RUN;
                         else                  cnt_nxt = cnt + 1'b1;
                     end
            ST_RUN:  if (!clocks_ok) nxt = ST_WAIT;
            default: nxt = ST_OFF;
        endcase
        if (!pdn_ok) nxt = ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_OFF;
            cnt        <= '0;
            frame_prev <= 1'b0;
        end else begin
            state      <= nxt;
            cnt        <= cnt_nxt;
            frame_prev <= frame_lvl;
        end
    end

    assign frame_start = tick & (state != ST_OFF);
endmodule

// File: rtl/pis_zero_gate.sv
module pis_zero_gate #(
    parameter int DATA_W   = 24,
    parameter int CHANNELS = 2
) (
    input  logic                             force_zero,
    input  logic [CHANNELS-1:0][DATA_W-1:0]  din,
    output logic [CHANNELS-1:0][DATA_W-1:0]  dout
);
    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        assign dout[c] = force_zero ? '0 : din[c];
    end
endmodule

// File: rtl/pdn_init_seq.sv
module pdn_init_seq
    import pis_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int INIT_FRAMES = 4129,
    parameter int MCLK_LIMIT  = 64,
    parameter int FRAME_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pdn_n,
    input  logic              mclk_in,
    input  logic              frame_clk,
    input  logic              fmt_i2s,
    input  logic [DATA_W-1:0] smp_l,
    input  logic [DATA_W-1:0] smp_r,
    output logic              filt_rst,
    output logic              force_zero,
    output logic              ready,
    output logic              frame_start,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r
);
    localparam int NCLK = 2;

    logic [2:0]              raw_in, sync_q;
    logic [NCLK-1:0]         clk_lvl, clk_ok;
    seq_state_e              state;
    seq_ctl_t                ctl;
    logic [1:0][DATA_W-1:0]  pair_in, pair_out;

    assign raw_in = {pdn_n, frame_clk, mclk_in};

    pis_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_q)
    );

    assign clk_lvl = sync_q[1:0];

    for (genvar g = 0; g < NCLK; g++) begin : g_watch
        localparam int LIM = (g == 0) ? MCLK_LIMIT : FRAME_LIMIT;
        pis_clk_watch #(.LIMIT(LIM)) u_watch (
            .clk     (clk),
            .rst     (rst),
            .lvl     (clk_lvl[g]),
            .present (clk_ok[g])
        );
    end

    pis_fsm #(.INIT_FRAMES(INIT_FRAMES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pdn_ok      (sync_q[2]),
        .mclk_ok     (clk_ok[0]),
        .fclk_ok     (clk_ok[1]),
        .frame_lvl   (sync_q[1]),
        .fmt_i2s     (fmt_i2s),
        .state       (state),
        .frame_start (frame_start)
    );

    assign ctl        = ctl_of(state);
    assign filt_rst   = ctl.filt_rst;
    assign force_zero = ctl.force_zero;
    assign ready      = ctl.ready;

    assign pair_in = {smp_r, smp_l};

    pis_zero_gate #(.DATA_W(DATA_W), .CHANNELS(2)) u_gate (
        .force_zero (force_zero),
        .din        (pair_in),
        .dout       (pair_out)
    );

    assign out_l = pair_out[0];
    assign out_r = pair_out[1];
endmodule

// File: rtl/pdn_init_seq_checker.sv
module pdn_init_seq_checker #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              pdn_n,
    input logic              filt_rst,
    input logic              force_zero,
    input logic              ready,
    input logic              frame_start,
    input logic [DATA_W-1:0] out_l,
    input logic [DATA_W-1:0] out_r
);
    logic [1:0] age;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end
    assign warm = (age == 2'd3);

    AST_PDN_HOLDS_FILTER: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(pdn_n, 3)) |-> filt_rst); // R2

    AST_PD_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
        filt_rst |-> (!ready && force_zero)); // R2

    AST_NO_SKIP_INIT: assert property (@(posedge clk) disable iff (rst)
        (warm && $fell(filt_rst)) |-> (force_zero && !ready)); // R3

    AST_READY_ON_FRAME_EDGE: assert property (@(posedge clk) disable iff (rst)
        (warm && $rose(ready)) |-> $past(frame_start)); // R4

    AST_ZERO_WHEN_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (out_l == '0 && out_r == '0)); // R5

    AST_FRAME_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R7
endmodule

bind pdn_init_seq pdn_init_seq_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pdn_n       (pdn_n),
    .filt_rst    (filt_rst),
    .force_zero  (force_zero),
    .ready       (ready),
    .frame_start (frame_start),
    .out_l       (out_l),
    .out_r       (out_r)
);

// File: tb/pdn_init_seq_bench.sv
`timescale 1ns/1ps
module pdn_init_seq_bench;
    localparam int DW     = 24;
    localparam int NFR    = 4129;
    localparam int HALF   = 4;
    localparam int M_LIM  = 8;
    localparam int F_LIM  = 24;
    localparam int NVEC   = 6;
    localparam logic [2*DW-1:0] VEC [NVEC] = '{
        48'h000001_FFFFFF, 48'h7FFFFF_800000, 48'hA5A5A5_5A5A5A,
        48'h123456_654321, 48'hFFFFFF_000001, 48'h800000_7FFFFF
    };

    logic          clk = 0;
    logic          rst = 1;
    logic          pdn_n = 0;
    logic          mclk_in = 0;
    logic          frame_clk = 0;
    logic          fmt_i2s = 0;
    logic [DW-1:0] smp_l = '0, smp_r = '0;
    logic          filt_rst, force_zero, ready, frame_start;
    logic [DW-1:0] out_l, out_r;

    logic mclk_en = 0, fclk_en = 0;
    int   fdiv = 0, sel_cnt = 0, opp_cnt = 0;
    int   n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    pdn_init_seq #(
        .DATA_W(DW), .INIT_FRAMES(NFR), .MCLK_LIMIT(M_LIM), .FRAME_LIMIT(F_LIM)
    ) u_pdn_init_seq (
        .clk(clk), .rst(rst), .pdn_n(pdn_n), .mclk_in(mclk_in),
        .frame_clk(frame_clk), .fmt_i2s(fmt_i2s), .smp_l(smp_l), .smp_r(smp_r),
        .filt_rst(filt_rst), .force_zero(force_zero), .ready(ready),
        .frame_start(frame_start), .out_l(out_l), .out_r(out_r)
    );

    always @(negedge clk) begin
        if (mclk_en) mclk_in <= ~mclk_in;
        if (fclk_en) begin
            if (fdiv == HALF - 1) begin
                fdiv      <= 0;
                frame_clk <= ~frame_clk;
                if ((~frame_clk) == ~fmt_i2s) sel_cnt <= sel_cnt + 1;
                else                          opp_cnt <= opp_cnt + 1;
            end else begin
                fdiv <= fdiv + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic wait_sel(input int k);
        int target;
        target = sel_cnt + k;
        wait (sel_cnt == target);
    endtask

    task automatic wait_opp(input int k);
        int target;
        target = opp_cnt + k;
        wait (opp_cnt == target);
    endtask

    // R5 / R6: walk the data table and compare both channels
    task automatic walk_table(input bit running, input string req);
        for (int i = 0; i < NVEC; i++) begin
            {smp_l, smp_r} = VEC[i];
            @(negedge clk);
            chk(req, {out_l, out_r}, running ? VEC[i] : '0);
        end
    endtask

    // R7: one pulse per selected edge, none for the other edge
    task automatic frame_pulse_check(input string req);
        int pulses;
        wait_sel(1);
        pulses = 0;
        for (int i = 0; i < HALF; i++) begin
            @(negedge clk);
            pulses += int'(frame_start);
        end
        chk({req, " selected edge"}, 48'(pulses), 48'd1);
        wait_opp(1);
        pulses = 0;
        for (int i = 0; i < HALF; i++) begin
            @(negedge clk);
            pulses += int'(frame_start);
        end
        chk({req, " other edge"}, 48'(pulses), 48'd0);
    endtask

    // R4: full start-up with both clocks already running
    task automatic exact_init(input logic fmt);
        int base;
        pdn_n   = 0;
        fmt_i2s = fmt;
        repeat (20) @(negedge clk);
        chk("R2 powered down before start-up", {45'd0, filt_rst, force_zero, ready}, 48'b110);
        wait_sel(1);
        @(negedge clk);
        pdn_n = 1;
        base  = sel_cnt;
        repeat (12) @(negedge clk);
        walk_table(1'b0, "R5 zero during start-up");
        wait (sel_cnt == base + NFR - 1);
        repeat (5) @(negedge clk);
        chk("R4 not ready one edge short", {46'd0, force_zero, ready}, 48'b10);
        wait (sel_cnt == base + NFR);
        repeat (5) @(negedge clk);
        chk("R4 ready on last edge", {46'd0, force_zero, ready}, 48'b01);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        smp_l = 24'hABCDEF;
        smp_r = 24'h135791;
        repeat (4) @(negedge clk);
        chk("R1 reset controls", {45'd0, filt_rst, force_zero, ready}, 48'b110);
        chk("R1 reset outputs zero", {out_l, out_r}, '0);
        rst = 0;
        @(negedge clk);
        chk("R1 after reset release", {45'd0, filt_rst, force_zero, ready}, 48'b110);

        // R3: released but no clocks, then only the frame clock
        pdn_n = 1;
        repeat (100) @(negedge clk);
        chk("R3 waiting without clocks", {45'd0, filt_rst, force_zero, ready}, 48'b010);
        fclk_en = 1;
        repeat (100) @(negedge clk);
        chk("R3 waiting without master clock", {45'd0, filt_rst, force_zero, ready}, 48'b010);
        mclk_en = 1;
        repeat (50) @(negedge clk);
        chk("R3 start-up not yet ready", {45'd0, filt_rst, force_zero, ready}, 48'b010);
        walk_table(1'b0, "R5 zero while starting");

        // R2 from start-up
        pdn_n = 0;
        repeat (3) @(negedge clk);
        chk("R2 power-down from start-up", {45'd0, filt_rst, force_zero, ready}, 48'b110);

        // Left-justified run
        exact_init(1'b0);
        walk_table(1'b1, "R6 pass-through running");
        frame_pulse_check("R7 rising edge mode");

        // R8: frame clock lost while running
        fclk_en = 0;
        smp_l = 24'h00FF00;
        smp_r = 24'h0F0F0F;
        repeat (F_LIM + 20) @(negedge clk);
        chk("R8 frame loss returns to wait", {45'd0, filt_rst, force_zero, ready}, 48'b010);
        chk("R8 frame loss zero outputs", {out_l, out_r}, '0);
        fclk_en = 1;
        repeat (60) @(negedge clk);
        chk("R8 clock return restarts start-up", {45'd0, filt_rst, force_zero, ready}, 48'b010);

        // I2S run
        exact_init(1'b1);
        frame_pulse_check("R7 falling edge mode");
        walk_table(1'b1, "R6 pass-through I2S");

        // R2 from running
        pdn_n = 0;
        repeat (3) @(negedge clk);
        chk("R2 power-down from running", {45'd0, filt_rst, force_zero, ready}, 48'b110);
        chk("R2 zero outputs powered down", {out_l, out_r}, '0);

        finish_run();
    end
endmodule